// File: doc/BRIEF.md
# Bus Activity Detect Power Monitor

This block watches the cycles seen on a peripheral bus and records, per device class, whether any recent traffic has touched that class. Each I/O or memory cycle is compared against a fixed set of legacy address windows: keyboard, serial ports, parallel ports, video and disk. Two further inputs report interrupt activity and bus-master or DMA activity. Every hit sets a sticky status bit that only hardware can set. Software clears a bit by writing a one to it.

Per-source enable bits decide which newly set status bits also set a single sticky global activity flag. While that flag and its global enable are both one, the system-management interrupt request stays high. The moment the flag goes from 0 to 1 can reload the first general-purpose timer. A separate set of reload enables lets four of the device classes reload a second timer directly. The timers are outside this block; it only drives one-cycle reload strobes.

The snooped bus cycles arrive on a valid/ready interface. The block always accepts, so `cyc_ready` is held at 1 and the bus never waits on the monitor. A cycle counts only in a clock where `cyc_valid` is 1. Registers use a plain write-enable and address port with a combinational read.

Top module: `actmon_top`

## Requirements
- R1: Status bit 7 sets after an I/O cycle to exactly address 0x60. A memory cycle to 0x60 does not set it. Neither does an I/O cycle to an address that differs above bit 15, such as 0x10060.
- R2: Status bit 6 sets after an I/O cycle anywhere in 0x2E8-0x2EF, 0x2F8-0x2FF, 0x3E8-0x3EF or 0x3F8-0x3FF.
- R3: Status bit 5 sets after an I/O cycle in 0x278-0x27F or 0x378-0x37F.
- R4: Status bit 4 sets after an I/O cycle in 0x3B0-0x3DF, or after a memory cycle in 0xA0000-0xBFFFF. An I/O cycle at a video memory address does not set it.
- R5: Status bit 3 sets after an I/O cycle in 0x170-0x177 or 0x1F0-0x1F7, or to 0x3F5 alone. An I/O cycle to 0x3F4 does not set it.
- R6: Status bit 1 follows `irq_act` and bit 0 follows `dma_act`. Status and enable bit 2 are reserved. Reload-enable bits 5, 2 and 1 are reserved. Reserved bits read as zero and ignore writes.
- R7: Status bits are sticky. A write of 1 to a bit at register address 0 clears it, and a write of 0 has no effect. A hardware set in the same cycle as a clear leaves the bit at 1.
- R8: The global flag, read at address 3 bit 0, sets when a status bit goes from 0 to 1 while its enable bit (address 1) is 1. It is sticky, and a write of 1 to it clears it.
- R9: `smi_req` is high exactly while the global flag and the global enable (address 4 bit 0) are both 1.
- R10: `gp0_reload` pulses for one cycle, together with the global flag becoming 1, when reload-enable bit 0 (address 2) is 1. It does not pulse when the flag was already set.
- R11: `gp1_reload` pulses for one cycle, together with status bit 7, 6, 4 or 3 going from 0 to 1, when the reload-enable bit in the same position is 1.
- R12: After reset, all registers read zero and `smi_req`, `gp0_reload` and `gp1_reload` are low.
- R13: `cyc_ready` is always 1. A cycle with `cyc_valid` low sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Snooped bus cycle present this clock |
| cyc_ready | output | 1 | Always 1; monitor never stalls the bus |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_addr | input | ADDR_W | Cycle address |
| irq_act | input | 1 | Primary interrupt activity |
| dma_act | input | 1 | Bus-master / DMA activity |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 status, 1 enable, 2 reload enable, 3 global flag, 4 global enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of selected register |
| smi_req | output | 1 | System-management interrupt request level |
| gp0_reload | output | 1 | First timer reload strobe |
| gp1_reload | output | 1 | Second timer reload strobe |

## Verification
The bench builds the block with its defaults: ADDR_W of 32 and DATA_W of 8. The 32-bit address lets it drive I/O cycles whose low sixteen bits hit a window while higher bits do not, which shows the decode compares the whole address and does not alias. The 8-bit data width covers every implemented and reserved bit of each register. This brings the write-one-to-clear behaviour, the set-beats-clear collision and the reserved-bit masks all within reach through the register port.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int NSRC = 8;
  localparam int NWIN = 12;
  localparam int WIN_AW = 20;

  localparam logic [NSRC-1:0] STAT_IMPL = 8'hFB;
  localparam logic [NSRC-1:0] RLD_IMPL  = 8'hD9;
  localparam logic [NSRC-1:0] GP1_SRC   = 8'hD8;

  localparam int SRC_KBD  = 7;
  localparam int SRC_SER  = 6;
  localparam int SRC_PAR  = 5;
  localparam int SRC_VID  = 4;
  localparam int SRC_DISK = 3;
  localparam int SRC_IRQ  = 1;
  localparam int SRC_DMA  = 0;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_EN    = 3'd1,
    SEL_RLD   = 3'd2,
    SEL_GSTAT = 3'd3,
    SEL_GEN   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic              is_mem;
    logic [WIN_AW-1:0] lo;
    logic [WIN_AW-1:0] hi;
    logic [2:0]        src;
  } win_t;

  function automatic win_t win_at(input int idx);
    win_t w;
    w = '{is_mem: 1'b0, lo: '0, hi: '0, src: 3'd0};
    case (idx)
      0:  w = '{1'b0, 20'h00060, 20'h00060, 3'(SRC_KBD)};
      1:  w = '{1'b0, 20'h003F8, 20'h003FF, 3'(SRC_SER)};
      2:  w = '{1'b0, 20'h002F8, 20'h002FF, 3'(SRC_SER)};
      3:  w = '{1'b0, 20'h003E8, 20'h003EF, 3'(SRC_SER)};
      4:  w = '{1'b0, 20'h002E8, 20'h002EF, 3'(SRC_SER)};
      5:  w = '{1'b0, 20'h00278, 20'h0027F, 3'(SRC_PAR)};
      6:  w = '{1'b0, 20'h00378, 20'h0037F, 3'(SRC_PAR)};
      7:  w = '{1'b0, 20'h003B0, 20'h003DF, 3'(SRC_VID)};
      8:  w = '{1'b1, 20'hA0000, 20'hBFFFF, 3'(SRC_VID)};
      9:  w = '{1'b0, 20'h001F0, 20'h001F7, 3'(SRC_DISK)};
      10: w = '{1'b0, 20'h00170, 20'h00177, 3'(SRC_DISK)};
      default: w = '{1'b0, 20'h003F5, 20'h003F5, 3'(SRC_DISK)};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/actmon_decode.sv
module actmon_decode
  import actmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              cyc_valid,
  input  logic              cyc_mem,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              irq_act,
  input  logic              dma_act,
  output logic [NSRC-1:0]   hit
);
  logic [NSRC-1:0] win_vec [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam win_t WD = win_at(w);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(WD.lo);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(WD.hi);
    logic match;
    assign match = cyc_valid && (cyc_mem == WD.is_mem) &&
                   (cyc_addr >= LO) && (cyc_addr <= HI);
    assign win_vec[w] = match ? (NSRC'(1) << WD.src) : '0;
  end

  always_comb begin
    hit = '0;
    for (int w = 0; w < NWIN; w++) hit = hit | win_vec[w];
    hit[SRC_IRQ] = hit[SRC_IRQ] | irq_act;
    hit[SRC_DMA] = hit[SRC_DMA] | dma_act;
  end
endmodule

// File: rtl/actmon_sticky.sv
module actmon_sticky #(
  parameter int           W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= IMPL[i] & (set[i] | (q[i] & ~clr[i]));
    end

    if (IMPL[i]) begin : g_chk
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q[i] && !clr[i]) |=> q[i]);
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> q[i]);
      assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q[i] && clr[i] && !set[i]) |=> !q[i]);
    end
  end

  assign rise = set & ~q & IMPL;
endmodule

// File: rtl/actmon_regs.sv
module actmon_regs
  import actmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]   status,
  input  logic              gflag,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   rld,
  output logic              gen,
  output logic [NSRC-1:0]   stat_clr,
  output logic              gclr,
  output logic [DATA_W-1:0] reg_rdata
);
  reg_sel_e        sel;
  logic [NSRC-1:0] wbyte;

  assign sel   = reg_sel_e'(reg_addr);
  assign wbyte = reg_wdata[NSRC-1:0];

  assign stat_clr = (reg_we && sel == SEL_STAT)  ? wbyte : '0;
  assign gclr     = reg_we && (sel == SEL_GSTAT) && wbyte[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      rld <= '0;
      gen <= 1'b0;
    end else if (reg_we) begin
      case (sel)
        SEL_EN:  en  <= wbyte & STAT_IMPL;
        SEL_RLD: rld <= wbyte & RLD_IMPL;
        SEL_GEN: gen <= wbyte[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STAT:  reg_rdata[NSRC-1:0] = status;
      SEL_EN:    reg_rdata[NSRC-1:0] = en;
      SEL_RLD:   reg_rdata[NSRC-1:0] = rld;
      SEL_GSTAT: reg_rdata[0]        = gflag;
      SEL_GEN:   reg_rdata[0]        = gen;
      default:   reg_rdata           = '0;
    endcase
  end

  assert_rsvd_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_EN) |=> !en[2]);
  assert_rsvd_rld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_RLD) |=> (rld[5] == 1'b0 && rld[2:1] == 2'b00));
endmodule

// File: rtl/actmon_top.sv
module actmon_top
  import actmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic              cyc_mem,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              irq_act,
  input  logic              dma_act,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              smi_req,
  output logic              gp0_reload,
  output logic              gp1_reload
);
  logic [NSRC-1:0] hit, status, stat_rise, stat_clr, en, rld;
  logic            gen, gclr, pset, gflag, grise;
  logic            gp0_q, gp1_q;

  assign cyc_ready = 1'b1;

  actmon_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cyc_valid (cyc_valid),
    .cyc_mem   (cyc_mem),
    .cyc_addr  (cyc_addr),
    .irq_act   (irq_act),
    .dma_act   (dma_act),
    .hit       (hit)
  );

  actmon_sticky #(.W(NSRC), .IMPL(STAT_IMPL)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (hit),
    .clr  (stat_clr),
    .q    (status),
    .rise (stat_rise)
  );

  assign pset = |(stat_rise & en);

  actmon_sticky #(.W(1), .IMPL(1'b1)) u_glob (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (pset),
    .clr  (gclr),
    .q    (gflag),
    .rise (grise)
  );

  actmon_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status   (status),
    .gflag    (gflag),
    .en       (en),
    .rld      (rld),
    .gen      (gen),
    .stat_clr (stat_clr),
    .gclr     (gclr),
    .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp0_q <= 1'b0;
      gp1_q <= 1'b0;
    end else begin
      gp0_q <= grise & rld[0];
      gp1_q <= |(stat_rise & rld & GP1_SRC);
    end
  end

  assign gp0_reload = gp0_q;
  assign gp1_reload = gp1_q;
  assign smi_req    = gflag & gen;

  assert_gp0_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gp0_reload |-> (gflag && !$past(gflag)));
  assert_gp1_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gp1_reload |-> |(status & $past(rld) & GP1_SRC));
  assert_gflag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gflag) |-> $past(|(hit & en)));
  assert_smi_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> gflag);
endmodule

// File: tb/tb_actmon_top.sv
module tb_actmon_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0, cyc_mem = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        irq_act = 1'b0, dma_act = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cyc_ready, smi_req, gp0_reload, gp1_reload;

  always #2 clk = ~clk;

  actmon_top dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_mem(cyc_mem), .cyc_addr(cyc_addr), .irq_act(irq_act), .dma_act(dma_act),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smi_req(smi_req), .gp0_reload(gp0_reload), .gp1_reload(gp1_reload)
  );

  typedef struct {
    string    tag;
    logic [7:0] rd;
    bit       smi, gp0, gp1;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_st = '0, m_en = '0, m_rl = '0;
  bit m_gf = 0, m_ge = 0;

  function automatic logic [7:0] ref_hit(bit v, bit m, logic [31:0] a);
    logic [7:0] h = '0;
    if (!v) return h;
    if (m) begin
      if (a >= 32'hA0000 && a <= 32'hBFFFF) h[4] = 1;
    end else begin
      if (a == 32'h60) h[7] = 1;
      if ((a >> 3) == (32'h3F8 >> 3) || (a >> 3) == (32'h2F8 >> 3) ||
          (a >> 3) == (32'h3E8 >> 3) || (a >> 3) == (32'h2E8 >> 3)) h[6] = 1;
      if ((a >> 3) == (32'h278 >> 3) || (a >> 3) == (32'h378 >> 3)) h[5] = 1;
      if (a >= 32'h3B0 && a <= 32'h3DF) h[4] = 1;
      if ((a >> 3) == (32'h1F0 >> 3) || (a >> 3) == (32'h170 >> 3) || a == 32'h3F5) h[3] = 1;
    end
    return h;
  endfunction

  task automatic step(bit v, bit m, logic [31:0] a, bit irq, bit dma,
                      bit we, logic [2:0] ra, logic [7:0] wd, string tag);
    logic [7:0] h, nw, clr;
    bit pset, gclr, g0, g1;
    exp_t e;
    @(negedge clk);
    cyc_valid = v; cyc_mem = m; cyc_addr = a; irq_act = irq; dma_act = dma;
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    h = (ref_hit(v, m, a) | {6'b0, irq, dma}) & 8'hFB;
    clr = (we && ra == 3'd0) ? wd : 8'h00;
    nw = h & ~m_st;
    pset = |(nw & m_en);
    gclr = we && ra == 3'd3 && wd[0];
    g0 = pset && !m_gf && m_rl[0];
    g1 = |(nw & m_rl & 8'hD8);
    m_st = ((m_st & ~clr) | h) & 8'hFB;
    m_gf = (m_gf && !gclr) || pset;
    if (we && ra == 3'd1) m_en = wd & 8'hFB;
    if (we && ra == 3'd2) m_rl = wd & 8'hD9;
    if (we && ra == 3'd4) m_ge = wd[0];
    case (ra)
      3'd0: e.rd = m_st;
      3'd1: e.rd = m_en;
      3'd2: e.rd = m_rl;
      3'd3: e.rd = {7'b0, m_gf};
      3'd4: e.rd = {7'b0, m_ge};
      default: e.rd = 8'h00;
    endcase
    e.tag = tag; e.smi = m_gf && m_ge; e.gp0 = g0; e.gp1 = g1;
    sb.push_back(e);
  endtask

  task automatic io(logic [31:0] a, string tag);  step(1, 0, a, 0, 0, 0, 3'd0, 8'h00, tag); endtask
  task automatic mem(logic [31:0] a, string tag); step(1, 1, a, 0, 0, 0, 3'd0, 8'h00, tag); endtask
  task automatic rd(logic [2:0] ra, string tag);  step(0, 0, 0, 0, 0, 0, ra, 8'h00, tag); endtask
  task automatic wr(logic [2:0] ra, logic [7:0] d, string tag); step(0, 0, 0, 0, 0, 1, ra, d, tag); endtask

  // Monitor: compares each expected item one time unit after the edge it belongs to
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (reg_rdata !== e.rd || smi_req !== e.smi || gp0_reload !== e.gp0 ||
          gp1_reload !== e.gp1 || cyc_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s: got rd=%h smi=%b gp0=%b gp1=%b rdy=%b exp rd=%h smi=%b gp0=%b gp1=%b rdy=1",
                 e.tag, reg_rdata, smi_req, gp0_reload, gp1_reload, cyc_ready,
                 e.rd, e.smi, e.gp0, e.gp1);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R12 reset state
    for (int r = 0; r < 5; r++) rd(3'(r), "R12 reset value");
    // R1 keyboard port
    io(32'h60, "R1 io 0x60");
    wr(0, 8'h80, "R7 w1c bit7");
    mem(32'h60, "R1 mem 0x60 ignored");
    io(32'h10060, "R1 high address no alias");
    io(32'h61, "R1 0x61 outside");
    // R2 serial
    io(32'h3FF, "R2 0x3FF");
    io(32'h2E8, "R2 0x2E8");
    wr(0, 8'hFF, "R7 clear all");
    io(32'h2F7, "R2 0x2F7 outside");
    io(32'h3EF, "R2 0x3EF");
    // R3 parallel
    wr(0, 8'hFF, "R7 clear all");
    io(32'h377, "R3 0x377 outside");
    io(32'h278, "R3 0x278");
    io(32'h37F, "R3 0x37F");
    // R4 video
    wr(0, 8'hFF, "R7 clear all");
    io(32'h3E0, "R4 0x3E0 outside");
    io(32'hA0000, "R4 io at video memory ignored");
    mem(32'hC0000, "R4 mem 0xC0000 outside");
    mem(32'hBFFFF, "R4 mem 0xBFFFF");
    wr(0, 8'h10, "R7 w1c bit4");
    io(32'h3B0, "R4 io 0x3B0");
    wr(0, 8'h10, "R7 w1c bit4");
    io(32'h3DF, "R4 io 0x3DF");
    // R5 disk
    wr(0, 8'hFF, "R7 clear all");
    io(32'h3F4, "R5 0x3F4 outside");
    io(32'h1F8, "R5 0x1F8 outside");
    io(32'h3F5, "R5 0x3F5");
    wr(0, 8'h08, "R7 w1c bit3");
    io(32'h177, "R5 0x177");
    wr(0, 8'h08, "R7 w1c bit3");
    io(32'h1F0, "R5 0x1F0");
    // R6 irq, dma and reserved bits
    wr(0, 8'hFF, "R7 clear all");
    step(0, 0, 0, 1, 0, 0, 3'd0, 8'h00, "R6 irq bit1");
    step(0, 0, 0, 0, 1, 0, 3'd0, 8'h00, "R6 dma bit0");
    wr(1, 8'hFF, "R6 enable reserved bit2 reads 0");
    wr(2, 8'hFF, "R6 reload-enable reserved bits read 0");
    wr(1, 8'h00, "R6 enable clear");
    wr(2, 8'h00, "R6 reload-enable clear");
    rd(5, "R6 unused address reads 0");
    // R13 invalid cycle
    wr(0, 8'hFF, "R7 clear all");
    step(0, 0, 32'h60, 0, 0, 0, 3'd0, 8'h00, "R13 valid low ignored");
    // R7 zero write, set-wins collision
    io(32'h60, "R7 set bit7");
    wr(0, 8'h00, "R7 zero write no effect");
    wr(0, 8'h80, "R7 clear bit7");
    io(32'h60, "R7 reset bit7");
    step(1, 0, 32'h60, 0, 0, 1, 3'd0, 8'h80, "R7 set beats clear");
    // R8 global flag
    wr(0, 8'hFF, "R7 clear all");
    io(32'h60, "R8 disabled source leaves flag");
    rd(3, "R8 flag still 0");
    wr(1, 8'h80, "R8 enable kbd");
    wr(0, 8'h80, "R7 clear bit7");
    io(32'h60, "R8 enabled source sets flag");
    rd(3, "R8 flag reads 1");
    // R9 smi level
    wr(4, 8'h01, "R9 global enable on, smi high");
    rd(3, "R9 smi held");
    wr(3, 8'h01, "R8 w1c flag, R9 smi low");
    // R10 gp0 reload
    wr(2, 8'h01, "R10 reload-enable bit0");
    wr(0, 8'hFF, "R7 clear all");
    io(32'h60, "R10 gp0 pulse");
    rd(3, "R10 pulse ends");
    wr(0, 8'hFF, "R7 clear all");
    io(32'h60, "R10 no pulse with flag already set");
    // R11 gp1 reload
    wr(3, 8'h01, "R8 clear flag");
    wr(2, 8'hFF, "R11 reload-enable all");
    wr(0, 8'hFF, "R7 clear all");
    io(32'h3F8, "R11 serial gp1 pulse");
    io(32'h3F9, "R11 already set no pulse");
    io(32'h278, "R11 parallel reserved no gp1");
    io(32'h1F3, "R11 disk gp1 pulse");
    step(0, 0, 0, 1, 0, 0, 3'd0, 8'h00, "R11 irq no gp1");
    rd(0, "R11 idle");
    repeat (3) @(posedge clk);
    #1;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule